// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Combined Interrupt

This block is a parallel I/O port of up to 32 pins that a processor reaches over a narrow 32-bit register bus. Software sets each pin's direction, drives output levels and reads back pin levels. It also selects which pins may raise the single combined interrupt line. Every input passes through a two-stage synchroniser before it is read or watched for transitions.

The interrupt condition is fixed when the block is built. It is one of rising edge, falling edge, either edge, or level high. In the three edge kinds, each transition of the chosen polarity sets a sticky per-pin capture flag, and software clears that flag by writing a one to it. In the level kind, no flag is kept: the line follows the synchronised pin levels through the enable mask.

The request side has no back-pressure. A request presented with `req_valid` is accepted on that clock edge, and a new one may follow on every cycle. A read answers exactly one cycle later with `rsp_valid` and the data. The response side has no ready signal and cannot be stalled.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output data, direction, enable-mask and capture registers are all zero, so every pin is an input (`pin_oe` = 0, `pin_out` = 0) and `irq` is low.
- R2: The register is selected by the byte address: 0x0 is pin data, 0x4 is direction, 0x8 is the interrupt enable mask, 0xC is edge capture. Any other address, including one whose two low bits are not zero, reads as zero and ignores writes.
- R3: Bits at positions at or above `PINS` read as zero in every register and ignore writes.
- R4: Writing the data register sets `pin_out`. `pin_oe` equals the direction register, where 1 means output. Reading the data register returns the synchronised level of every pin, whatever its direction.
- R5: With the rising kind, only a 0→1 transition sets a capture bit. With the falling kind, only a 1→0 transition sets one. With the either-edge kind, both transitions set one.
- R6: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged, and a set bit stays set until it is cleared.
- R7: In the edge kinds, `irq` is high exactly when (capture AND mask) is nonzero. A mask bit of 0 does not stop that pin's edges from being captured.
- R8: In the level kind, `irq` is high exactly when (synchronised pins AND mask) is nonzero, with no latching. It falls as soon as the pin falls.
- R9: An edge that arrives in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R10: Every read is answered one cycle after it is accepted, with `rsp_valid` high for that single cycle. Back-to-back requests on consecutive cycles are all served in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | PINS | Pin levels from the pads (asynchronous) |
| pin_out | output | PINS | Output levels to the pads |
| pin_oe | output | PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a pin transition reaching the capture stage, and a software write-one-to-clear of the same capture bit. The bench provokes this by changing an input pin two cycles before it issues the clearing write. The synchroniser delays the edge by exactly that much, so the edge and the write meet on the same clock edge. A read of the capture register then passes only if the bit survived. Separately, the bench runs four instances, one per trigger kind, on the same stimulus, and judges each instance's interrupt line against its own rule.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int DATA_W = 32;

  // Word indices (byte address >> 2)
  localparam int IDX_DATA = 0;
  localparam int IDX_DIR  = 1;
  localparam int IDX_MASK = 2;
  localparam int IDX_CAP  = 3;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] sync_out
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic meta_q, stable_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[g];
        stable_q <= meta_q;
      end
    end
    assign sync_out[g] = stable_q;
  end
endmodule

// File: rtl/gpio_port_edge.sv
module gpio_port_edge
  import gpio_port_pkg::*;
#(
  parameter int    PINS    = 32,
  parameter trig_e TRIGGER = TRIG_RISE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_s,
  input  logic [PINS-1:0] clr,
  output logic [PINS-1:0] cap
);
  if (TRIGGER == TRIG_LEVEL) begin : g_level
    assign cap = '0;
  end else begin : g_edge
    logic [PINS-1:0] prev_q, hit, cap_q;

    if (TRIGGER == TRIG_RISE) begin : g_rise
      assign hit = pin_s & ~prev_q;
    end else if (TRIGGER == TRIG_FALL) begin : g_fall
      assign hit = ~pin_s & prev_q;
    end else begin : g_both
      assign hit = pin_s ^ prev_q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= '0;
        cap_q  <= '0;
      end else begin
        prev_q <= pin_s;
        cap_q  <= (cap_q & ~clr) | hit;  // new edge wins over clear
      end
    end
    assign cap = cap_q;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int    PINS    = 32,
  parameter int    ADDR_W  = 6,
  parameter trig_e TRIGGER = TRIG_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             sel_data, sel_dir, sel_mask, sel_cap;
  logic             wr;
  logic [PINS-1:0]  out_q, dir_q, mask_q, cap, pin_s, clr;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [DATA_W-1:0] zext(input logic [PINS-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[PINS-1:0] = v;
    return r;
  endfunction

  assign idx      = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign sel_data = aligned && (idx == IDX_W'(IDX_DATA));
  assign sel_dir  = aligned && (idx == IDX_W'(IDX_DIR));
  assign sel_mask = aligned && (idx == IDX_W'(IDX_MASK));
  assign sel_cap  = aligned && (idx == IDX_W'(IDX_CAP));
  assign wr       = req_valid && req_write;

  gpio_port_sync #(.PINS(PINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
  );

  assign clr = (wr && sel_cap) ? req_wdata[PINS-1:0] : '0;

  gpio_port_edge #(.PINS(PINS), .TRIGGER(TRIGGER)) edge_i (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .clr(clr), .cap(cap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      if (sel_data) out_q  <= req_wdata[PINS-1:0];
      if (sel_dir)  dir_q  <= req_wdata[PINS-1:0];
      if (sel_mask) mask_q <= req_wdata[PINS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_data)      rd_mux = zext(pin_s);
    else if (sel_dir)  rd_mux = zext(dir_q);
    else if (sel_mask) rd_mux = zext(mask_q);
    else if (sel_cap)  rd_mux = zext(cap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
    assign irq = |(pin_s & mask_q);
  end else begin : g_irq_edge
    assign irq = |(cap & mask_q);
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              irq,
  input logic [PINS-1:0]   mask_q,
  input logic [PINS-1:0]   cap
);
  logic cap_wr, dir_wr, dat_wr;
  assign cap_wr = req_valid && req_write && (req_addr == ADDR_W'(12));
  assign dir_wr = req_valid && req_write && (req_addr == ADDR_W'(4));
  assign dat_wr = req_valid && req_write && (req_addr == ADDR_W'(0));

  assert_read_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_upper_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (({32'b0, rsp_rdata} >> PINS) == 64'b0));

  assert_oe_tracks_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pin_oe == $past(req_wdata[PINS-1:0])));

  assert_out_tracks_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (pin_out == $past(req_wdata[PINS-1:0])));

  assert_mask_blocks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_capture_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_wr |=> ((cap & $past(cap)) == $past(cap)));
endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .mask_q(mask_q), .cap(cap)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  import gpio_port_pkg::*;
  localparam int NP = 12;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] pins = '0;

  logic rsp_valid, irq_rise;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pin_out, pin_oe;
  logic rv_f, rv_b, rv_l, irq_fall, irq_both, irq_lvl;
  logic [31:0] rd_f, rd_b, rd_l;
  logic [NP-1:0] po_f, po_b, po_l, oe_f, oe_b, oe_l;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  gpio_port #(.PINS(NP), .ADDR_W(AW), .TRIGGER(TRIG_RISE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pins[NP-1:0]), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq_rise));
  gpio_port #(.PINS(NP), .ADDR_W(AW), .TRIGGER(TRIG_FALL)) dut_fall (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_f),
    .rsp_rdata(rd_f), .pin_in(pins[NP-1:0]), .pin_out(po_f),
    .pin_oe(oe_f), .irq(irq_fall));
  gpio_port #(.PINS(NP), .ADDR_W(AW), .TRIGGER(TRIG_BOTH)) dut_both (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_b),
    .rsp_rdata(rd_b), .pin_in(pins[NP-1:0]), .pin_out(po_b),
    .pin_oe(oe_b), .irq(irq_both));
  gpio_port #(.PINS(NP), .ADDR_W(AW), .TRIGGER(TRIG_LEVEL)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_l),
    .rsp_rdata(rd_l), .pin_in(pins[NP-1:0]), .pin_out(po_l),
    .pin_oe(oe_l), .irq(irq_lvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Driver: issues a read and queues what the monitor must see next cycle
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 irq", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 0);
    rd(6'h4, 0, "R1 dir");
    rd(6'h8, 0, "R1 mask");
    rd(6'hC, 0, "R1 cap");

    wr(6'h4, 32'hFFFF_FFFF);
    check("R4 R3 pin_oe", 32'(pin_oe), 32'hFFF);
    rd(6'h4, 32'hFFF, "R3 dir upper bits");
    wr(6'h0, 32'h0000_0A5A);
    check("R4 pin_out", 32'(pin_out), 32'hA5A);
    rd(6'h10, 0, "R2 unmapped read");
    rd(6'h5, 0, "R2 misaligned read");
    wr(6'h14, 32'h0);
    wr(6'h6, 32'h0);
    rd(6'h4, 32'hFFF, "R2 dir after ignored writes");
    wr(6'h8, 32'hFFFF_F000);
    rd(6'h8, 0, "R3 mask upper ignored");

    pins = 32'hFFFF_F123;
    cyc(4);
    rd(6'h0, 32'h123, "R4 R3 pin data");
    rd(6'hC, 32'h123, "R5 rising captured");
    check("R7 masked edges no irq", 32'(irq_rise), 0);
    wr(6'h8, 32'h1);
    check("R7 irq rise", 32'(irq_rise), 1);
    check("R8 irq level", 32'(irq_lvl), 1);
    check("R5 no falling edge", 32'(irq_fall), 0);
    check("R5 both kind", 32'(irq_both), 1);

    wr(6'hC, 32'h2);
    rd(6'hC, 32'h121, "R6 clear one");
    wr(6'hC, 32'h0);
    rd(6'hC, 32'h121, "R6 zero write keeps");
    wr(6'hC, 32'h1);
    check("R6 R7 irq after clear", 32'(irq_rise), 0);
    check("R8 level not latched by clear", 32'(irq_lvl), 1);

    pins = 32'h0000_0122;
    cyc(4);
    check("R5 falling captured", 32'(irq_fall), 1);
    check("R5 rise ignores fall", 32'(irq_rise), 0);
    check("R8 level follows pin", 32'(irq_lvl), 0);
    check("R5 both sees fall", 32'(irq_both), 1);
    rd(6'hC, 32'h120, "R5 rise cap unchanged");
    wr(6'hC, 32'hFFF);
    rd(6'hC, 0, "R6 clear all");

    // R9: edge reaches capture on the same edge as the clearing write
    pins = 32'h0000_0126;
    cyc(2);
    wr(6'hC, 32'h4);
    rd(6'hC, 32'h4, "R9 edge beats clear");

    pins = 32'h0000_0127;
    cyc(4);
    check("R8 level high", 32'(irq_lvl), 1);
    wr(6'h8, 32'h0);
    check("R7 R8 mask off", {30'd0, irq_lvl, irq_rise}, 0);

    rd(6'h4, 32'hFFF, "R10 back-to-back a");
    rd(6'h8, 32'h0, "R10 back-to-back b");
    rd(6'h0, 32'h127, "R10 back-to-back c");
    cyc(2);
    check("R10 all responses seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule